// File: doc/BRIEF.md
# Blocking Write-Through Direct-Mapped Data Cache

This block is a first-level data cache for 32-bit word loads and stores. It sits between a core's memory pipeline and a shared cluster bus. It is direct mapped. Each line holds eight 32-bit words, kept in eight separate word banks, and every line has a valid bit. The core presents one request per cycle while `rdy` is high. The tag and data arrays are read in the cycle the request is accepted. The tag is compared in the following cycle, so a stream of load hits flows at one request per cycle.

Stores are write-through and never allocate a line. Every store, and every load that misses, stops the pipeline and asks for the cluster bus. The request is driven onto the bus in the cycle after the grant. A store is acknowledged to the core in that same cycle, and a store hit also updates its one word. A load miss waits for a snooped bus response tagged with this core's ID. The cache forwards the selected word to the core in the cycle the response appears, and writes the whole line into the arrays in the same cycle. While a line is being written, a new request to that line is held off for one cycle.

Top module: `wt_dcache`

## Requirements
- R1: After reset every line is invalid, `rdy` is high, and `rsp_valid`, `bus_req` and `bus_out_valid` are low. The first load to any address after a reset misses.
- R2: A load that hits gives `rsp_valid` with the stored word, the request address and the request message in the cycle after it is accepted. Consecutive load hits are accepted on consecutive cycles with `rdy` staying high.
- R3: Address bits [1:0] are ignored. Bits [4:2] pick the word, the next INDEX_W bits pick the line, and the remaining 32-INDEX_W-5 bits are the tag. Two addresses that differ only in the tag evict each other.
- R4: A store, or a load miss, drops `rdy` in its lookup cycle. `bus_req` is then high from the following cycle until the cycle in which `bus_gnt` is sampled high.
- R5: In the cycle after the grant, `bus_out_valid` is high and `bus_out_addr`, `bus_out_data`, `bus_out_msg` and `bus_out_id` carry the request address, data and message and CORE_ID.
- R6: A request whose message equals STORE_MSG (default 5'h02) is a store, and any other message is a load. A store is acknowledged with `rsp_valid`, its address, data and message in the cycle `bus_out_valid` is high, and `rdy` is high in that cycle.
- R7: A store hit rewrites only the addressed word of the line. A store miss leaves the cache unchanged, so a later load to that address misses.
- R8: A load miss completes in the cycle `snp_valid` is high with `snp_id` equal to CORE_ID. In that cycle `rsp_valid` is high, `rsp_data` is word [4:2] of `snp_line` (word k at bits 32k+31:32k) and `rsp_msg` is `snp_msg`. The whole line is filled, so later loads to any word of it hit.
- R9: A snooped response whose `snp_id` differs from CORE_ID is ignored: no response is given, and the cache keeps waiting.
- R10: In a cycle that writes a line (a fill or a store hit), a new request to the same line index sees `rdy` low and is accepted in the next cycle. A request to another line is accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_addr | input | 32 | Request byte address (word aligned) |
| req_data | input | 32 | Store data |
| req_msg | input | 5 | Request message (STORE_MSG marks a store) |
| rdy | output | 1 | Cache accepts a request this cycle |
| rsp_valid | output | 1 | Response to core valid |
| rsp_addr | output | 32 | Address of the answered request |
| rsp_data | output | 32 | Load data or store data echo |
| rsp_msg | output | 5 | Response message |
| bus_req | output | 1 | Request for the cluster bus |
| bus_gnt | input | 1 | Cluster bus grant |
| bus_out_valid | output | 1 | Request driven on the cluster bus |
| bus_out_addr | output | 32 | Bus request address |
| bus_out_data | output | 32 | Bus request data |
| bus_out_msg | output | 5 | Bus request message |
| bus_out_id | output | ID_W | Requesting core ID |
| snp_valid | input | 1 | Snooped response valid |
| snp_id | input | ID_W | Core ID of the snooped response |
| snp_msg | input | 5 | Snooped response message |
| snp_line | input | 256 | Snooped line data, word k at bits 32k+31:32k |

## Verification
The bench builds the cache with INDEX_W = 2, which gives four lines and a 25-bit tag, and with ID_W = 2 and CORE_ID = 1. With only four lines, every line can be filled and every word of every line swept with a short run. Evictions, store hits and misses, and same-line and other-line collisions can all be produced at chosen points. Grant delays of zero to three cycles, and a foreign-ID snoop, are mixed into the sweep.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  localparam int WORD_W = 32;
  localparam int MSG_W  = 5;
  localparam int OFF_W  = 3;
  localparam int BANKS  = 1 << OFF_W;
  localparam int LINE_W = WORD_W * BANKS;

  typedef enum logic [1:0] {
    ST_IDLE,  // lookups flow
    ST_ASK,   // waiting for bus grant
    ST_SEND,  // request on the bus
    ST_WAIT   // load miss waiting for snooped response
  } wtc_state_e;
endpackage

// File: rtl/wtc_sdp_ram.sv
module wtc_sdp_ram #(
  parameter int W  = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R10
  rdw_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !(we && re && (waddr == raddr)));
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl import wtc_pkg::*; (
  input  logic       clk,
  input  logic       rst,
  input  logic       lookup,
  input  logic       need_bus,
  input  logic       is_store,
  input  logic       gnt,
  input  logic       snp_mine,
  output wtc_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (lookup && need_bus) state <= ST_ASK;
        ST_ASK:  if (gnt) state <= ST_SEND;
        ST_SEND: state <= is_store ? ST_IDLE : ST_WAIT;
        ST_WAIT: if (snp_mine) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache import wtc_pkg::*; #(
  parameter int              INDEX_W   = 4,
  parameter int              ID_W      = 3,
  parameter logic [ID_W-1:0] CORE_ID   = '0,
  parameter logic [4:0]      STORE_MSG = 5'h02
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic [31:0]       req_data,
  input  logic [4:0]        req_msg,
  output logic              rdy,
  output logic              rsp_valid,
  output logic [31:0]       rsp_addr,
  output logic [31:0]       rsp_data,
  output logic [4:0]        rsp_msg,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              bus_out_valid,
  output logic [31:0]       bus_out_addr,
  output logic [31:0]       bus_out_data,
  output logic [4:0]        bus_out_msg,
  output logic [ID_W-1:0]   bus_out_id,
  input  logic              snp_valid,
  input  logic [ID_W-1:0]   snp_id,
  input  logic [4:0]        snp_msg,
  input  logic [255:0]      snp_line
);
  localparam int TAG_W = WORD_W - INDEX_W - OFF_W - 2;
  localparam int LINES = 1 << INDEX_W;
  localparam int IDX_LO = 2 + OFF_W;

  // address fields
  logic [INDEX_W-1:0] req_idx, s1_idx;
  logic [OFF_W-1:0]   req_off, s1_off;
  logic [TAG_W-1:0]   s1_tag, tag_rd;

  // stage-1 (lookup) registers
  logic              s1_vld;
  logic [31:0]       s1_addr, s1_data;
  logic [MSG_W-1:0]  s1_msg;
  logic              hit_q;
  logic [LINES-1:0]  line_vld;

  wtc_state_e state;
  logic accept, lookup, s1_store, tag_hit, need_bus;
  logic snp_mine, fill_we, st_we, line_wr, collide;
  logic [WORD_W-1:0] bank_rd [BANKS];
  logic [WORD_W-1:0] hit_word, snp_word;

  assign req_idx  = req_addr[IDX_LO +: INDEX_W];
  assign req_off  = req_addr[2 +: OFF_W];
  assign s1_idx   = s1_addr[IDX_LO +: INDEX_W];
  assign s1_off   = s1_addr[2 +: OFF_W];
  assign s1_tag   = s1_addr[WORD_W-1 -: TAG_W];

  assign accept   = req_valid && rdy;
  assign lookup   = s1_vld;
  assign s1_store = (s1_msg == STORE_MSG);
  assign tag_hit  = line_vld[s1_idx] && (tag_rd == s1_tag);
  assign need_bus = s1_store || !tag_hit;

  assign snp_mine = (state == ST_WAIT) && snp_valid && (snp_id == CORE_ID);
  assign fill_we  = snp_mine;
  assign st_we    = (state == ST_SEND) && s1_store && hit_q;
  assign line_wr  = fill_we || st_we;
  assign collide  = req_valid && line_wr && (req_idx == s1_idx);

  always_comb begin
    unique case (state)
      ST_IDLE: rdy = !(lookup && need_bus);
      ST_SEND: rdy = s1_store;
      ST_WAIT: rdy = snp_mine;
      default: rdy = 1'b0;
    endcase
    if (collide) rdy = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld   <= 1'b0;
      s1_addr  <= '0;
      s1_data  <= '0;
      s1_msg   <= '0;
      hit_q    <= 1'b0;
      line_vld <= '0;
    end else begin
      s1_vld <= accept;
      if (accept) begin
        s1_addr <= req_addr;
        s1_data <= req_data;
        s1_msg  <= req_msg;
      end
      if (lookup) hit_q <= tag_hit;
      if (fill_we) line_vld[s1_idx] <= 1'b1;
    end
  end

  wtc_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .lookup   (lookup),
    .need_bus (need_bus),
    .is_store (s1_store),
    .gnt      (bus_gnt),
    .snp_mine (snp_mine),
    .state    (state)
  );

  wtc_sdp_ram #(.W(TAG_W), .AW(INDEX_W)) u_tag (
    .clk   (clk),
    .rst   (rst),
    .re    (accept),
    .raddr (req_idx),
    .rdata (tag_rd),
    .we    (fill_we),
    .waddr (s1_idx),
    .wdata (s1_tag)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic              bank_re, bank_we;
    logic [WORD_W-1:0] bank_wd;
    assign bank_re = accept && (req_off == OFF_W'(b));
    assign bank_we = fill_we || (st_we && (s1_off == OFF_W'(b)));
    // the fill owns the write port whenever both want it
    assign bank_wd = fill_we ? snp_line[b*WORD_W +: WORD_W] : s1_data;
    wtc_sdp_ram #(.W(WORD_W), .AW(INDEX_W)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .re    (bank_re),
      .raddr (req_idx),
      .rdata (bank_rd[b]),
      .we    (bank_we),
      .waddr (s1_idx),
      .wdata (bank_wd)
    );
  end

  assign hit_word = bank_rd[s1_off];
  assign snp_word = snp_line[s1_off*WORD_W +: WORD_W];

  assign rsp_valid = (lookup && !s1_store && tag_hit)
                   || ((state == ST_SEND) && s1_store) || snp_mine;
  assign rsp_addr  = s1_addr;
  assign rsp_data  = snp_mine ? snp_word
                   : ((state == ST_SEND) ? s1_data : hit_word);
  assign rsp_msg   = snp_mine ? snp_msg : s1_msg;

  assign bus_req       = (state == ST_ASK);
  assign bus_out_valid = (state == ST_SEND);
  assign bus_out_addr  = s1_addr;
  assign bus_out_data  = s1_data;
  assign bus_out_msg   = s1_msg;
  assign bus_out_id    = CORE_ID;

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req);
  // R4
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !rdy);
  // R5
  issue_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
    bus_out_valid |-> $past(bus_req && bus_gnt));
  // R6
  store_ack_chk: assert property (@(posedge clk) disable iff (rst)
    bus_out_valid && (bus_out_msg == STORE_MSG) |-> rsp_valid && (rsp_data == bus_out_data));
  // R9
  foreign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) && (!snp_valid || snp_id != CORE_ID) |-> !rsp_valid);
endmodule

// File: tb/test_wt_dcache.sv
module test_wt_dcache;
  localparam int IW = 2;
  localparam int IDW = 2;
  localparam logic [IDW-1:0] MY_ID = 2'd1;
  localparam logic [4:0] ST_MSG = 5'h02;
  localparam logic [4:0] LD_MSG = 5'h01;
  localparam int TW = 32 - IW - 5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, bus_gnt = 1'b0, snp_valid = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic [4:0] req_msg = '0, snp_msg = '0;
  logic [IDW-1:0] snp_id = '0;
  logic [255:0] snp_line = '0;
  logic rdy, rsp_valid, bus_req, bus_out_valid;
  logic [31:0] rsp_addr, rsp_data, bus_out_addr, bus_out_data;
  logic [4:0] rsp_msg, bus_out_msg;
  logic [IDW-1:0] bus_out_id;

  int vectors = 0, fails = 0, cyc = 0;
  logic res [4];
  logic [TW-1:0] rtag [4];
  logic [31:0] ovl [logic [31:0]];

  always #2 clk = ~clk;

  wt_dcache #(.INDEX_W(IW), .ID_W(IDW), .CORE_ID(MY_ID), .STORE_MSG(ST_MSG)) i_wt_dcache (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .req_msg(req_msg), .rdy(rdy), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_data(rsp_data), .rsp_msg(rsp_msg), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_out_valid(bus_out_valid), .bus_out_addr(bus_out_addr), .bus_out_data(bus_out_data),
    .bus_out_msg(bus_out_msg), .bus_out_id(bus_out_id), .snp_valid(snp_valid),
    .snp_id(snp_id), .snp_msg(snp_msg), .snp_line(snp_line));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx, input int w);
    return (32'(tag) << (IW + 5)) | (32'(idx) << 5) | (32'(w) << 2);
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] a);
    logic [31:0] wa = {a[31:2], 2'b00};
    if (ovl.exists(wa)) return ovl[wa];
    return (wa * 32'h0100_0193) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [255:0] line_of(input logic [31:0] a);
    logic [255:0] l;
    for (int b = 0; b < 8; b++) l[b*32 +: 32] = word_of({a[31:5], 5'b0} | (32'(b) << 2));
    return l;
  endfunction

  function automatic logic hit_of(input logic [31:0] a);
    int idx = int'(a[IW+4:5]);
    return res[idx] && (rtag[idx] == a[31 -: TW]);
  endfunction

  task automatic wait_bus(input int dly);
    @(negedge clk); #1 chk("R4 bus_req raised", 32'(bus_req), 1);
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); #1 chk("R4 bus_req held", 32'(bus_req), 1);
    end
    bus_gnt = 1'b1;
    @(negedge clk); bus_gnt = 1'b0; #1;
    chk("R5 bus_out_valid", 32'(bus_out_valid), 1);
    chk("R5 bus_out_id", 32'(bus_out_id), 32'(MY_ID));
  endtask

  task automatic present(input logic [31:0] a, input logic [4:0] m, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_msg = m; req_data = d;
    #1 chk("R2 rdy before accept", 32'(rdy), 1);
    @(negedge clk); req_valid = 1'b0; #1;
  endtask

  task automatic do_load(input logic [31:0] a, input int dly, input logic foreign);
    logic h = hit_of(a);
    present(a, LD_MSG, 32'h0);
    if (h) begin
      chk("R2 hit rsp_valid", 32'(rsp_valid), 1);
      chk("R2 hit data", rsp_data, word_of(a));
      chk("R2 hit addr", rsp_addr, a);
      return;
    end
    chk("R8 miss no rsp", 32'(rsp_valid), 0);
    chk("R4 miss rdy low", 32'(rdy), 0);
    wait_bus(dly);
    chk("R5 bus_out_addr", bus_out_addr, a);
    chk("R5 load no ack", 32'(rsp_valid), 0);
    @(negedge clk);
    if (foreign) begin
      snp_valid = 1'b1; snp_id = MY_ID ^ 2'd3; snp_line = '1; snp_msg = 5'h1F;
      #1 chk("R9 foreign ignored", 32'(rsp_valid), 0);
      @(negedge clk); snp_valid = 1'b0;
      #1 chk("R9 still waiting", 32'(rdy), 0);
      @(negedge clk);
    end
    snp_valid = 1'b1; snp_id = MY_ID; snp_line = line_of(a); snp_msg = 5'h11;
    #1;
    chk("R8 bypass rsp_valid", 32'(rsp_valid), 1);
    chk("R8 bypass data", rsp_data, word_of(a));
    chk("R8 bypass msg", 32'(rsp_msg), 32'h11);
    @(negedge clk); snp_valid = 1'b0;
    res[int'(a[IW+4:5])] = 1'b1; rtag[int'(a[IW+4:5])] = a[31 -: TW];
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input int dly);
    present(a, ST_MSG, d);
    chk("R4 store no early rsp", 32'(rsp_valid), 0);
    chk("R4 store rdy low", 32'(rdy), 0);
    wait_bus(dly);
    chk("R5 store bus data", bus_out_data, d);
    chk("R5 store bus msg", 32'(bus_out_msg), 32'(ST_MSG));
    chk("R6 store ack", 32'(rsp_valid), 1);
    chk("R6 store ack data", rsp_data, d);
    chk("R6 store rdy", 32'(rdy), 1);
    ovl[a] = d;
  endtask

  task automatic burst(input int tag, input int idx);
    for (int w = 0; w < 8; w++) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = mk(tag, idx, w); req_msg = LD_MSG;
      #1 chk("R2 stream rdy", 32'(rdy), 1);
      if (w > 0) begin
        chk("R2 stream rsp", 32'(rsp_valid), 1);
        chk("R2 stream data", rsp_data, word_of(mk(tag, idx, w - 1)));
      end
    end
    @(negedge clk); req_valid = 1'b0;
    #1 chk("R2 stream last", rsp_data, word_of(mk(tag, idx, 7)));
  endtask

  task automatic collide_load(input logic [31:0] a1, input logic [31:0] a2);
    logic same = (a1[IW+4:5] == a2[IW+4:5]);
    present(a1, LD_MSG, 32'h0);
    wait_bus(0);
    @(negedge clk);
    snp_valid = 1'b1; snp_id = MY_ID; snp_line = line_of(a1); snp_msg = 5'h11;
    req_valid = 1'b1; req_addr = a2; req_msg = LD_MSG;
    #1 chk("R10 collision rdy", 32'(rdy), same ? 0 : 1);
    res[int'(a1[IW+4:5])] = 1'b1; rtag[int'(a1[IW+4:5])] = a1[31 -: TW];
    @(negedge clk); snp_valid = 1'b0;
    if (same) begin
      #1 chk("R10 accepted next cycle", 32'(rdy), 1);
      @(negedge clk);
    end
    req_valid = 1'b0;
    #1 chk("R10 follower hit", 32'(rsp_valid), 1);
    chk("R10 follower data", rsp_data, word_of(a2));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog all act=%0d exp=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin res[i] = 1'b0; rtag[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 rdy after reset", 32'(rdy), 1);
    chk("R1 no rsp", 32'(rsp_valid), 0);
    chk("R1 no bus_req", 32'(bus_req), 0);
    chk("R1 no bus_out", 32'(bus_out_valid), 0);
    // fill and sweep every line (R3 field split, R8 fill)
    for (int idx = 0; idx < 4; idx++) begin
      do_load(mk(5, idx, idx) | 32'(idx & 3), idx, idx == 2);
      burst(5, idx);
    end
    // R3 eviction by tag
    do_load(mk(9, 1, 0), 1, 1'b0);
    do_load(mk(5, 1, 4), 0, 1'b0);
    // R7 store hit changes one word only
    do_store(mk(5, 1, 3), 32'hCAFE_0003, 2);
    burst(5, 1);
    // R7 store miss does not allocate
    do_store(mk(12, 2, 6), 32'hBEEF_0606, 0);
    do_load(mk(12, 2, 6), 3, 1'b0);
    burst(12, 2);
    // R10 same-line and other-line collisions
    collide_load(mk(20, 3, 1), mk(20, 3, 5));
    collide_load(mk(21, 0, 2), mk(12, 2, 1));
    // R1 reset invalidates everything
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) res[i] = 1'b0;
    do_load(mk(5, 1, 3), 0, 1'b0);
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule